// File: doc/BRIEF.md
# RAID P/Q Parity Engine

This block computes the two RAID-6 style parity bytes for one byte position of a stripe. The sources for that position are presented one after another on a byte-wide stream, one source per accepted cycle. P is the plain XOR of all of them. Q is the XOR of every source after each one has been multiplied in GF(2^8) by its own programmable coefficient. The reduction polynomial used by the multiplier comes from a global configuration input.

An operation is opened with a start pulse. The pulse carries the source-count field, an optional continuation flag and the transfer length in byte positions. The engine then consumes `length` positions, each made of the same number of lanes, and emits P and Q for each position. In continuation mode three more lanes follow the ordinary sources in every position: the previous P, the previous Q and the previous Q again. These fold the earlier result into the new one, so parity can be built up over several passes. A start whose fields are out of range is refused: it raises the error flag and no operation begins.

Top module: `pq_parity_engine`

## Requirements
- R1: `cntField` holds the number of ordinary sources minus one. Field values 1 to 15 (2 to 16 sources) are accepted when `start` is high and `busy` is low, and `busy` rises in the following cycle when `xferLen` is not zero.
- R2: A start with `cntField` equal to 0 (fewer than 2 sources) or 16 or more (more than 16 sources) sets `errFlag` in the following cycle, leaves `busy` low and produces no output.
- R3: A start with `xferLen` above 1048576 (1 MiB) is refused as in R2. A length of exactly 1048576 is accepted.
- R4: `pOut` is the XOR of every lane byte of one position, continuation lanes included.
- R5: `qOut` is the XOR over the ordinary sources of GF(2^8) products of source i and coefficient byte i, taken from `qCoefs[8*i+7:8*i]`. The field is reduced by x^8 plus the polynomial whose low eight coefficients are `gfPoly` (0x1D gives x^8+x^4+x^3+x^2+1).
- R6: A lane whose coefficient is 0 adds nothing to Q but still adds to P. Presenting one source twice with coefficients c and 0 gives P = 0 and Q = c times that source.
- R7: With `contMode` set, three lanes follow the N ordinary sources in each position. They take Q coefficients 0, 0 and 1 and P coefficient 1. When they carry oldP, oldQ and oldQ, the outputs are P xor oldP and Q xor oldQ.
- R8: `outValid` is high for exactly one cycle, the cycle after the last lane of a position is accepted. The accumulation restarts at the first lane of the next position.
- R9: `busy` stays high until the last lane of the last position is accepted and falls in the same cycle that the final `outValid` rises. A `start` while `busy` is high is ignored.
- R10: After reset `busy`, `errFlag` and `outValid` are low. An accepted start clears `errFlag`.
- R11: Cycles with `srcValid` low neither advance the lane position nor change the accumulated result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens an operation when idle |
| cntField | input | 5 | Ordinary source count minus one |
| contMode | input | 1 | Append the three continuation lanes |
| xferLen | input | 24 | Byte positions in the transfer |
| gfPoly | input | 8 | Low byte of the GF(2^8) reduction polynomial |
| qCoefs | input | 128 | Q coefficient per source, byte i at bits 8i+7:8i |
| srcValid | input | 1 | A lane byte is presented |
| srcByte | input | 8 | Lane byte |
| busy | output | 1 | Operation in progress |
| errFlag | output | 1 | Last start was refused |
| outValid | output | 1 | P and Q valid for one position |
| pOut | output | 8 | P parity byte |
| qOut | output | 8 | Q parity byte |

## Verification
The assertions take for granted that `qCoefs`, `gfPoly` and the mode fields stay stable while an operation runs, and that lanes are offered only while `busy` is high. The stimulus respects this: it changes the coefficient table and the polynomial only between operations, and it drives `srcValid` only inside an open operation. Outside an operation it only pulses `start`, including deliberate pulses while busy. The random part varies the source count, the coefficients, the data and the gaps between lanes. The directed part covers the count and length limits, the single-source trick and continuation over an earlier result.

// File: rtl/pq_pkg.sv
package pq_pkg;

  typedef struct packed {
    logic       take;
    logic       first;
    logic       last;
    logic [7:0] coef;
  } pqStrobe_t;

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b,
                                       input logic [7:0] poly);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[7] ? ((sh << 1) ^ poly) : (sh << 1);
    end
    return acc;
  endfunction

endpackage

// File: rtl/pq_ctl.sv
module pq_ctl
  import pq_pkg::*;
#(
  parameter int MAX_SRC = 16,
  parameter int CNT_W   = 5,
  parameter int LEN_W   = 24,
  parameter int MAX_LEN = 1048576
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [CNT_W-1:0]     cntField,
  input  logic                 contMode,
  input  logic [LEN_W-1:0]     xferLen,
  input  logic [MAX_SRC*8-1:0] qCoefs,
  input  logic                 srcValid,
  output pqStrobe_t            strb,
  output logic                 busy,
  output logic                 errFlag
);
  localparam int IDX_W  = $clog2(MAX_SRC);
  localparam int LANE_W = CNT_W + 1;

  logic [7:0]        coefTbl [MAX_SRC];
  logic [LANE_W-1:0] laneIdx, lastLane, nSrc;
  logic [LEN_W-1:0]  posLeft;
  logic              badStart;

  for (genvar g = 0; g < MAX_SRC; g++) begin : gCoef
    assign coefTbl[g] = qCoefs[8*g +: 8];
  end

  assign badStart = (cntField == '0) || (int'(cntField) > MAX_SRC - 1) ||
                    (int'(xferLen) > MAX_LEN);

  always_comb begin
    strb.take  = busy && srcValid;
    strb.first = (laneIdx == '0);
    strb.last  = (laneIdx == lastLane);
    if (laneIdx < nSrc)
      strb.coef = coefTbl[laneIdx[IDX_W-1:0]];
    else if (laneIdx == nSrc + LANE_W'(2))
      strb.coef = 8'h01;
    else
      strb.coef = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      errFlag  <= 1'b0;
      laneIdx  <= '0;
      lastLane <= '0;
      nSrc     <= '0;
      posLeft  <= '0;
    end else if (!busy) begin
      if (start) begin
        if (badStart) begin
          errFlag <= 1'b1;
        end else begin
          errFlag  <= 1'b0;
          busy     <= (xferLen != '0);
          nSrc     <= LANE_W'(cntField) + LANE_W'(1);
          lastLane <= LANE_W'(cntField) + (contMode ? LANE_W'(3) : LANE_W'(0));
          posLeft  <= xferLen;
          laneIdx  <= '0;
        end
      end
    end else if (srcValid) begin
      if (laneIdx == lastLane) begin
        laneIdx <= '0;
        posLeft <= posLeft - LEN_W'(1);
        if (posLeft == LEN_W'(1)) busy <= 1'b0;
      end else begin
        laneIdx <= laneIdx + LANE_W'(1);
      end
    end
  end
endmodule

// File: rtl/pq_dp.sv
module pq_dp
  import pq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  pqStrobe_t  strb,
  input  logic [7:0] gfPoly,
  input  logic [7:0] srcByte,
  output logic       outValid,
  output logic [7:0] pOut,
  output logic [7:0] qOut
);
  logic [7:0] pAcc, qAcc, pNext, qNext, prod;

  assign prod  = gfMul(srcByte, strb.coef, gfPoly);
  assign pNext = (strb.first ? 8'h00 : pAcc) ^ srcByte;
  assign qNext = (strb.first ? 8'h00 : qAcc) ^ prod;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pAcc     <= '0;
      qAcc     <= '0;
      outValid <= 1'b0;
      pOut     <= '0;
      qOut     <= '0;
    end else begin
      outValid <= strb.take && strb.last;
      if (strb.take) begin
        pAcc <= pNext;
        qAcc <= qNext;
        if (strb.last) begin
          pOut <= pNext;
          qOut <= qNext;
        end
      end
    end
  end
endmodule

// File: rtl/pq_parity_engine.sv
module pq_parity_engine
  import pq_pkg::*;
#(
  parameter int MAX_SRC = 16,
  parameter int CNT_W   = 5,
  parameter int LEN_W   = 24,
  parameter int MAX_LEN = 1048576
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [CNT_W-1:0]     cntField,
  input  logic                 contMode,
  input  logic [LEN_W-1:0]     xferLen,
  input  logic [7:0]           gfPoly,
  input  logic [MAX_SRC*8-1:0] qCoefs,
  input  logic                 srcValid,
  input  logic [7:0]           srcByte,
  output logic                 busy,
  output logic                 errFlag,
  output logic                 outValid,
  output logic [7:0]           pOut,
  output logic [7:0]           qOut
);
  pqStrobe_t strb;

  pq_ctl #(.MAX_SRC(MAX_SRC), .CNT_W(CNT_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) ctl_i (
    .clk(clk), .rstN(rstN), .start(start), .cntField(cntField), .contMode(contMode),
    .xferLen(xferLen), .qCoefs(qCoefs), .srcValid(srcValid), .strb(strb),
    .busy(busy), .errFlag(errFlag)
  );

  pq_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .gfPoly(gfPoly), .srcByte(srcByte),
    .outValid(outValid), .pOut(pOut), .qOut(qOut)
  );
endmodule

// File: rtl/pq_checker.sv
module pq_checker #(
  parameter int MAX_SRC = 16,
  parameter int CNT_W   = 5,
  parameter int LEN_W   = 24,
  parameter int MAX_LEN = 1048576
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [CNT_W-1:0] cntField,
  input logic [LEN_W-1:0] xferLen,
  input logic             srcValid,
  input logic             busy,
  input logic             errFlag,
  input logic             outValid
);
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !busy); // R2

  AST_BAD_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && (cntField == '0 || int'(cntField) > MAX_SRC - 1)) |=> (errFlag && !busy)); // R2

  AST_LEN_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && int'(xferLen) > MAX_LEN) |=> (errFlag && !busy)); // R3

  AST_OUT_AFTER_LANE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(busy && srcValid)); // R8

  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid); // R8

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> !errFlag); // R9
endmodule

bind pq_parity_engine pq_checker #(.MAX_SRC(MAX_SRC), .CNT_W(CNT_W), .LEN_W(LEN_W),
  .MAX_LEN(MAX_LEN)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .cntField(cntField), .xferLen(xferLen),
  .srcValid(srcValid), .busy(busy), .errFlag(errFlag), .outValid(outValid)
);

// File: tb/pq_parity_engine_tb_top.sv
module pq_parity_engine_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [4:0]   cntField = '0;
  logic         contMode = 1'b0;
  logic [23:0]  xferLen = '0;
  logic [7:0]   gfPoly = 8'h1D;
  logic [127:0] qCoefs = '0;
  logic         srcValid = 1'b0;
  logic [7:0]   srcByte = '0;
  logic         busy, errFlag, outValid;
  logic [7:0]   pOut, qOut;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [7:0] lastP, lastQ;
  logic [7:0] keepP [4];
  logic [7:0] keepQ [4];

  always #2.5 clk = ~clk;

  pq_parity_engine dut_i (
    .clk(clk), .rstN(rstN), .start(start), .cntField(cntField), .contMode(contMode),
    .xferLen(xferLen), .gfPoly(gfPoly), .qCoefs(qCoefs), .srcValid(srcValid),
    .srcByte(srcByte), .busy(busy), .errFlag(errFlag), .outValid(outValid),
    .pOut(pOut), .qOut(qOut)
  );

  // carry-less product then reduction from the top bit down
  function automatic logic [7:0] refMul(input logic [7:0] a, input logic [7:0] b,
                                        input logic [7:0] poly);
    logic [15:0] prod = '0;
    for (int i = 0; i < 8; i++) if (b[i]) prod ^= 16'(a) << i;
    for (int k = 15; k >= 8; k--) if (prod[k]) prod ^= {8'h01, poly} << (k - 8);
    return prod[7:0];
  endfunction

  function automatic logic [7:0] laneCoef(input int lane, input int n);
    if (lane < n) return qCoefs[8*lane +: 8];
    if (lane == n + 2) return 8'h01;
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doStart(input int field, input bit cont, input int len);
    @(negedge clk);
    start = 1'b1; cntField = 5'(field); contMode = cont; xferLen = 24'(len);
    @(negedge clk);
    start = 1'b0;
  endtask

  // one position; lanes beyond n are given explicitly in extra (continuation)
  task automatic doPosition(input int n, input bit cont, input logic [7:0] extra [3],
                            input int maxGap, input bit lastPos);
    int lanes = n + (cont ? 3 : 0);
    logic [7:0] expP = 8'h00;
    logic [7:0] expQ = 8'h00;
    for (int l = 0; l < lanes; l++) begin
      logic [7:0] b = (l < n) ? 8'($urandom) : extra[l - n];
      int gap = (maxGap > 0) ? int'($urandom % (maxGap + 1)) : 0;
      srcValid = 1'b0;
      repeat (gap) begin
        @(negedge clk);
        check("R11 no output during gap", 32'(outValid), 32'h0);
      end
      srcValid = 1'b1; srcByte = b;
      expP ^= b;
      expQ ^= refMul(b, laneCoef(l, n), gfPoly);
      @(negedge clk);
      if (l == lanes - 1) begin
        check("R8 outValid after last lane", 32'(outValid), 32'h1);
        check("R4 P parity", 32'(pOut), 32'(expP));
        check("R5 Q parity", 32'(qOut), 32'(expQ));
        check("R9 busy at final lane", 32'(busy), lastPos ? 32'h0 : 32'h1);
      end else begin
        check("R8 no early outValid", 32'(outValid), 32'h0);
      end
    end
    srcValid = 1'b0;
    lastP = expP; lastQ = expQ;
  endtask

  task automatic randomCoefs();
    for (int i = 0; i < 16; i++) qCoefs[8*i +: 8] = 8'($urandom);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL R9 watchdog expired actual=%0d expected<150000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] none [3];
    logic [7:0] ex [3];
    none = '{8'h00, 8'h00, 8'h00};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 reset busy", 32'(busy), 32'h0);
    check("R10 reset errFlag", 32'(errFlag), 32'h0);
    check("R10 reset outValid", 32'(outValid), 32'h0);

    // R2 illegal counts
    doStart(0, 1'b0, 4);
    check("R2 one source rejected err", 32'(errFlag), 32'h1);
    check("R2 one source rejected busy", 32'(busy), 32'h0);
    doStart(16, 1'b0, 4);
    check("R2 seventeen sources rejected", 32'(errFlag), 32'h1);
    doStart(31, 1'b0, 4);
    check("R2 field 31 rejected", 32'(errFlag), 32'h1);
    check("R2 no outValid after refusal", 32'(outValid), 32'h0);

    // R1 / R10 accepted start clears the flag, minimum and maximum counts
    randomCoefs();
    doStart(1, 1'b0, 2);
    check("R10 errFlag cleared", 32'(errFlag), 32'h0);
    check("R1 busy after two-source start", 32'(busy), 32'h1);
    doPosition(2, 1'b0, none, 0, 1'b0);
    doPosition(2, 1'b0, none, 0, 1'b1);
    doStart(15, 1'b0, 1);
    check("R1 sixteen sources accepted", 32'(busy), 32'h1);
    doPosition(16, 1'b0, none, 1, 1'b1);

    // R6 single source through duplication
    qCoefs[7:0] = 8'h53; qCoefs[15:8] = 8'h00;
    doStart(1, 1'b0, 1);
    begin
      logic [7:0] s = 8'hCA;
      srcValid = 1'b1; srcByte = s; @(negedge clk);
      srcByte = s; @(negedge clk); srcValid = 1'b0;
      check("R6 single source P", 32'(pOut), 32'h0);
      check("R6 single source Q", 32'(qOut), 32'(refMul(s, 8'h53, gfPoly)));
    end

    // R9 start while busy ignored
    randomCoefs();
    doStart(3, 1'b0, 1);
    doStart(0, 1'b0, 1);
    check("R9 start while busy ignored err", 32'(errFlag), 32'h0);
    check("R9 still busy", 32'(busy), 32'h1);
    doPosition(4, 1'b0, none, 2, 1'b1);

    // R7 continuation over an earlier pass
    randomCoefs();
    doStart(4, 1'b0, 3);
    for (int p = 0; p < 3; p++) begin
      doPosition(5, 1'b0, none, 1, p == 2);
      keepP[p] = lastP; keepQ[p] = lastQ;
    end
    randomCoefs();
    doStart(4, 1'b1, 3);
    for (int p = 0; p < 3; p++) begin
      ex = '{keepP[p], keepQ[p], keepQ[p]};
      doPosition(5, 1'b1, ex, 1, p == 2);
      check("R7 continuation P equals new xor old", 32'(pOut),
            32'(lastP));
    end

    // R5 another polynomial, random operations
    for (int t = 0; t < 40; t++) begin
      int n = 2 + int'($urandom % 15);
      int len = 1 + int'($urandom % 4);
      bit cont = bit'($urandom % 2);
      gfPoly = (t % 3 == 0) ? 8'h2B : 8'h1D;
      randomCoefs();
      doStart(n - 1, cont, len);
      for (int p = 0; p < len; p++) begin
        ex = '{8'($urandom), 8'($urandom), 8'($urandom)};
        doPosition(n, cont, ex, 2, p == len - 1);
      end
    end
    gfPoly = 8'h1D;

    // R3 length limit
    doStart(2, 1'b0, 1048577);
    check("R3 over-length rejected", 32'(errFlag), 32'h1);
    check("R3 over-length not busy", 32'(busy), 32'h0);
    doStart(2, 1'b0, 1048576);
    check("R3 exact limit accepted err", 32'(errFlag), 32'h0);
    check("R3 exact limit accepted busy", 32'(busy), 32'h1);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 reset ends operation", 32'(busy), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule